// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Counter

This block keeps a free-running time-of-day value for a precision timing domain. It holds a nanosecond count and a binary fraction of a nanosecond. On every system clock cycle in which counting is enabled, it adds a programmable per-cycle step to that value. The step is a 32.32 fixed-point number of nanoseconds. For an input clock of F Hz the nominal step is (10^9 << 32) / F. Software trims the rate by writing a slightly larger or smaller step. The count carries on without any disturbance to the accumulated fraction.

A small register interface reaches four 64-bit locations: a configuration word, the step, the current time, and a captured event stamp. Writing the time register sets the absolute nanosecond count. An external event input is synchronised and watched for a chosen edge. When that edge arrives, the current nanosecond count is latched into the stamp register. A one-cycle pulse marks the capture.

Top module: `precision_time_counter`

## Requirements
- R1: After reset every register reads zero, the stamp pulse is low, and the time does not advance.
- R2: While config bit 0 is 1, each clock edge adds the step (upper 32 bits whole ns, lower 32 bits fraction) to the 96-bit value formed by the 64-bit nanosecond count and the 32-bit fraction. The time register (address 2) returns the nanosecond part.
- R3: While config bit 0 is 0, neither the nanosecond count nor the fraction changes. When counting resumes, it continues from the kept fraction.
- R4: A step written at address 1 is used for the first time at the edge after the write edge. The fraction accumulated so far is carried over unchanged.
- R5: The nanosecond count wraps modulo 2^64. A carry out of the top bit is dropped.
- R6: A write to address 2 loads the nanosecond count and clears the fraction at that edge. This load takes precedence over the add for that cycle.
- R7: With config bit 8 set, the event input passes through two synchroniser flops. A selected edge then latches the nanosecond count. Config bit 9 picks the edge: 1 means rising, 0 means falling. If the input changes before edge E0, the stamp holds the count present between edges E1 and E2, is readable at address 3 after E2, and the stamp pulse is high for exactly the cycle after E2.
- R8: When config bit 8 is 0, or on the opposite edge, the stamp keeps its value and no pulse occurs.
- R9: Reads are combinational on the address: 0 is config (only bits 0, 8 and 9 are stored; all other bits read 0), 1 is step, 2 is time, 3 is stamp. Address 3 is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| evt_in | input | 1 | Asynchronous external event |
| stamp_pulse | output | 1 | One-cycle pulse after an event capture |

## Verification
The accumulator is swept cycle by cycle over the nominal steps for five input clock rates. An integer step of 8 ns and 10 ns shows plain addition. Steps of 6.4 ns, 1.552 ns and 3.000000003 ns show that the fraction carries into the nanosecond count at the right cycles. A step change in the middle of a run, and a stop followed by a restart, separate a design that keeps the fraction from one that drops or resets it. Loading a value just below 2^64 separates modular wrap from saturation. The event input is tried on both edges, with capture enabled and disabled, while counting. This pins the capture to the cycle after synchronisation and tells a correct edge match from a level match.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [1:0] {
        REG_CFG   = 2'd0,
        REG_STEP  = 2'd1,
        REG_TIME  = 2'd2,
        REG_STAMP = 2'd3
    } reg_sel_e;

    localparam int unsigned CFG_RUN_BIT      = 0;
    localparam int unsigned CFG_CAP_EN_BIT   = 8;
    localparam int unsigned CFG_CAP_RISE_BIT = 9;

    typedef struct packed {
        logic cap_rise;
        logic cap_en;
        logic run;
    } cfg_t;

endpackage

// File: rtl/ptc_regfile.sv
module ptc_regfile
    import ptc_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned STEP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] ns_i,
    input  logic [DATA_W-1:0] stamp_i,
    output cfg_t              cfg_o,
    output logic [STEP_W-1:0] step_o,
    output logic              time_load_o,
    output logic [DATA_W-1:0] reg_rdata
);

    typedef struct packed {
        cfg_t              cfg;
        logic [STEP_W-1:0] step;
    } rf_t;

    rf_t      rf_d, rf_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        rf_d = rf_q;
        if (reg_we) begin
            case (sel)
                REG_CFG: begin
                    rf_d.cfg.run      = reg_wdata[CFG_RUN_BIT];
                    rf_d.cfg.cap_en   = reg_wdata[CFG_CAP_EN_BIT];
                    rf_d.cfg.cap_rise = reg_wdata[CFG_CAP_RISE_BIT];
                end
                REG_STEP: rf_d.step = reg_wdata[STEP_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_CFG: begin
                reg_rdata[CFG_RUN_BIT]      = rf_q.cfg.run;
                reg_rdata[CFG_CAP_EN_BIT]   = rf_q.cfg.cap_en;
                reg_rdata[CFG_CAP_RISE_BIT] = rf_q.cfg.cap_rise;
            end
            REG_STEP:  reg_rdata = DATA_W'(rf_q.step);
            REG_TIME:  reg_rdata = ns_i;
            REG_STAMP: reg_rdata = stamp_i;
            default:   reg_rdata = '0;
        endcase
    end

    assign cfg_o       = rf_q.cfg;
    assign step_o      = rf_q.step;
    assign time_load_o = reg_we && (sel == REG_TIME);

endmodule

// File: rtl/ptc_accum.sv
module ptc_accum #(
    parameter int unsigned NS_W   = 64,
    parameter int unsigned FRAC_W = 32,
    parameter int unsigned STEP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              load_i,
    input  logic [NS_W-1:0]   load_ns_i,
    output logic [NS_W-1:0]   ns_o,
    output logic [FRAC_W-1:0] frac_o
);

    localparam int unsigned ACC_W = NS_W + FRAC_W;

    typedef struct packed {
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
    } acc_t;

    acc_t             acc_d, acc_q;
    logic [ACC_W-1:0] sum;

    assign sum = acc_q + ACC_W'(step_i);

    always_comb begin
        acc_d = acc_q;
        if (load_i) begin
            acc_d.ns   = load_ns_i;
            acc_d.frac = '0;
        end else if (run_i) begin
            acc_d = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign ns_o   = acc_q.ns;
    assign frac_o = acc_q.frac;

endmodule

// File: rtl/ptc_event.sv
module ptc_event #(
    parameter int unsigned NS_W        = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_i,
    input  logic            cap_en_i,
    input  logic            cap_rise_i,
    input  logic [NS_W-1:0] ns_i,
    output logic [NS_W-1:0] stamp_o,
    output logic            pulse_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
        logic [NS_W-1:0]        stamp;
        logic                   pulse;
    } ev_t;

    ev_t  ev_d, ev_q;
    logic synced, rise, fall, hit;

    assign synced = ev_q.sync[SYNC_STAGES-1];
    assign rise   = synced & ~ev_q.last;
    assign fall   = ~synced & ev_q.last;
    assign hit    = cap_en_i & (cap_rise_i ? rise : fall);

    always_comb begin
        ev_d       = ev_q;
        ev_d.sync  = {ev_q.sync[SYNC_STAGES-2:0], evt_i};
        ev_d.last  = synced;
        ev_d.pulse = hit;
        if (hit) ev_d.stamp = ns_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign stamp_o = ev_q.stamp;
    assign pulse_o = ev_q.pulse;

endmodule

// File: rtl/precision_time_counter.sv
module precision_time_counter
    import ptc_pkg::*;
#(
    parameter int unsigned NS_W        = 64,
    parameter int unsigned FRAC_W      = 32,
    parameter int unsigned STEP_INT_W  = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [NS_W-1:0] reg_wdata,
    output logic [NS_W-1:0] reg_rdata,
    input  logic            evt_in,
    output logic            stamp_pulse
);

    localparam int unsigned STEP_W = STEP_INT_W + FRAC_W;

    cfg_t              cfg;
    logic [STEP_W-1:0] step;
    logic              time_load;
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
    logic [NS_W-1:0]   stamp;

    ptc_regfile #(
        .DATA_W (NS_W),
        .STEP_W (STEP_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .ns_i        (ns),
        .stamp_i     (stamp),
        .cfg_o       (cfg),
        .step_o      (step),
        .time_load_o (time_load),
        .reg_rdata   (reg_rdata)
    );

    ptc_accum #(
        .NS_W   (NS_W),
        .FRAC_W (FRAC_W),
        .STEP_W (STEP_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (cfg.run),
        .step_i    (step),
        .load_i    (time_load),
        .load_ns_i (reg_wdata),
        .ns_o      (ns),
        .frac_o    (frac)
    );

    ptc_event #(
        .NS_W        (NS_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_in),
        .cap_en_i   (cfg.cap_en),
        .cap_rise_i (cfg.cap_rise),
        .ns_i       (ns),
        .stamp_o    (stamp),
        .pulse_o    (stamp_pulse)
    );

endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
    parameter int unsigned NS_W   = 64,
    parameter int unsigned FRAC_W = 32,
    parameter int unsigned STEP_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic [NS_W-1:0]   reg_wdata,
    input logic [NS_W-1:0]   reg_rdata,
    input logic              run_i,
    input logic              load_i,
    input logic [STEP_W-1:0] step_i,
    input logic [NS_W-1:0]   ns_i,
    input logic [FRAC_W-1:0] frac_i,
    input logic [NS_W-1:0]   stamp_i,
    input logic              pulse_i
);

    localparam int unsigned ACC_W = NS_W + FRAC_W;

    logic [ACC_W-1:0] acc_now;
    logic [ACC_W-1:0] acc_step;

    assign acc_now  = {ns_i, frac_i};
    assign acc_step = ACC_W'(step_i);

    // R2: an enabled cycle advances the value by exactly one step (mod 2^96)
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i) |=> (acc_now == $past(acc_now + acc_step)));

    // R3: a disabled cycle keeps count and fraction
    p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(acc_now));

    // R6: a time write loads the count and clears the fraction
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ns_i == $past(reg_wdata) && frac_i == '0));

    // R7: a capture pulse never lasts more than one cycle
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> !pulse_i);

    // R8: the stamp only changes together with a capture pulse
    p_stamp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_i |-> $stable(stamp_i));

    // R9: unstored config bits read as zero
    p_cfg_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[NS_W-1:10] == '0 && reg_rdata[7:1] == '0));

endmodule

bind precision_time_counter ptc_checker #(
    .NS_W   (NS_W),
    .FRAC_W (FRAC_W),
    .STEP_W (STEP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .run_i     (cfg.run),
    .load_i    (time_load),
    .step_i    (step),
    .ns_i      (ns),
    .frac_i    (frac),
    .stamp_i   (stamp),
    .pulse_i   (stamp_pulse)
);

// File: tb/precision_time_counter_bench.sv
module precision_time_counter_bench;

    logic        clk;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        evt_in;
    logic        stamp_pulse;

    int tests;
    int fails;

    // bench-side model of the requirements
    logic [95:0] m_acc;
    logic [63:0] m_step;
    logic        m_run;
    logic [63:0] m_stamp;

    precision_time_counter u_precision_time_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .evt_in      (evt_in),
        .stamp_pulse (stamp_pulse)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_edge(input bit we, input logic [1:0] a, input logic [63:0] d);
        if (we && a == 2'd2)  m_acc = {d, 32'h0};
        else if (m_run)       m_acc = m_acc + {32'h0, m_step};
        if (we && a == 2'd1)  m_step = d;
        if (we && a == 2'd0)  m_run = d[0];
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        model_edge(1'b1, a, d);
    endtask

    task automatic tick();
        @(negedge clk);
        model_edge(1'b0, 2'd0, 64'h0);
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_time(input string req);
        logic [63:0] v;
        rd(2'd2, v);
        chk(req, v, m_acc[95:32]);
    endtask

    // drive event level, then follow synchroniser and capture timing
    task automatic ev(input bit lvl, input bit hit, input string req);
        logic [63:0] exp_stamp, v;
        evt_in = lvl;
        tick();                       // E0
        tick();                       // E1
        exp_stamp = hit ? m_acc[95:32] : m_stamp;
        chk({req, " pulse before"}, {63'h0, stamp_pulse}, 64'h0);
        tick();                       // E2
        chk({req, " pulse"}, {63'h0, stamp_pulse}, {63'h0, hit});
        rd(2'd3, v);
        chk({req, " stamp"}, v, exp_stamp);
        m_stamp = exp_stamp;
        tick();
        chk({req, " pulse after"}, {63'h0, stamp_pulse}, 64'h0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [63:0]  v;
        logic [127:0] nom;
        longint unsigned freqs [5];
        tests = 0; fails = 0;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0; evt_in = 1'b0;
        m_acc = '0; m_step = '0; m_run = 1'b0; m_stamp = '0;
        freqs[0] = 64'd125000000;
        freqs[1] = 64'd100000000;
        freqs[2] = 64'd156250000;
        freqs[3] = 64'd644531250;
        freqs[4] = 64'd333333333;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reset read", v, 64'h0);
        end
        chk("R1 pulse low", {63'h0, stamp_pulse}, 64'h0);
        repeat (4) tick();
        chk_time("R1 no advance");

        // R9: config masking and step readback
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(2'd0, v);
        chk("R9 cfg stored bits", v, 64'h300);
        wr(2'd0, 64'h0);

        // R2: nominal steps for several clock rates, checked every cycle
        for (int f = 0; f < 5; f++) begin
            nom = (128'd1000000000 << 32) / {64'h0, freqs[f]};
            wr(2'd1, nom[63:0]);
            rd(2'd1, v);
            chk("R9 step readback", v, nom[63:0]);
            wr(2'd2, 64'h1000_0000 * (f + 1));
            wr(2'd0, 64'h1);
            for (int m = 0; m < 48; m++) begin
                tick();
                chk_time("R2 accumulate");
            end
            wr(2'd0, 64'h0);
        end
        // R2: 125 MHz gives exactly 8 ns per cycle
        wr(2'd1, 64'h8_0000_0000);
        wr(2'd2, 64'd500);
        wr(2'd0, 64'h1);
        repeat (10) tick();
        rd(2'd2, v);
        chk("R2 8ns x10", v, 64'd580);

        // R3: freeze keeps fraction
        wr(2'd1, 64'h0000_0000_8000_0000);    // 0.5 ns
        wr(2'd2, 64'd1000);
        tick();                               // frac = 0.5
        wr(2'd0, 64'h0);                      // adds once more at this edge -> 1001.0
        for (int m = 0; m < 6; m++) begin
            tick();
            rd(2'd2, v);
            chk("R3 frozen", v, 64'd1001);
        end
        wr(2'd2, 64'd2000);
        wr(2'd0, 64'h1);
        tick();
        wr(2'd0, 64'h0);                      // 2001.0 after two halves
        repeat (3) tick();
        wr(2'd0, 64'h1);
        tick();
        rd(2'd2, v);
        chk("R3 resume keeps fraction", v, 64'd2001);
        tick();
        rd(2'd2, v);
        chk("R3 resume carry", v, 64'd2002);

        // R4: step change mid-run keeps the fraction
        wr(2'd1, 64'h6_6666_6666);            // ~6.4 ns
        for (int m = 0; m < 7; m++) begin
            tick();
            chk_time("R4 before change");
        end
        wr(2'd1, 64'h1_8D4F_DF3B);            // ~1.552 ns
        chk_time("R4 write edge uses old step");
        for (int m = 0; m < 9; m++) begin
            tick();
            chk_time("R4 after change");
        end

        // R5: wrap modulo 2^64
        wr(2'd0, 64'h0);
        wr(2'd1, 64'h1_8000_0000);            // 1.5 ns
        wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFD);
        wr(2'd0, 64'h1);
        tick();
        rd(2'd2, v);
        chk("R5 pre wrap", v, 64'hFFFF_FFFF_FFFF_FFFE);
        tick();
        rd(2'd2, v);
        chk("R5 wrap to zero", v, 64'h0);
        tick();
        rd(2'd2, v);
        chk("R5 after wrap", v, 64'h1);

        // R6: load wins over add and clears fraction
        wr(2'd1, 64'h0000_0000_8000_0000);
        tick();
        wr(2'd2, 64'd7777);
        rd(2'd2, v);
        chk("R6 load no add", v, 64'd7777);
        tick();
        rd(2'd2, v);
        chk("R6 fraction cleared", v, 64'd7777);
        tick();
        rd(2'd2, v);
        chk("R6 carry after load", v, 64'd7778);

        // R7, R8: event capture while counting
        wr(2'd1, 64'h3_0000_000D);
        wr(2'd0, 64'h301);                    // run, capture on, rising
        ev(1'b1, 1'b1, "R7 rising capture");
        ev(1'b0, 1'b0, "R8 falling ignored when rising selected");
        wr(2'd0, 64'h101);                    // falling
        ev(1'b1, 1'b0, "R8 rising ignored when falling selected");
        ev(1'b0, 1'b1, "R7 falling capture");
        wr(2'd0, 64'h201);                    // capture disabled
        ev(1'b1, 1'b0, "R8 disabled rising");
        ev(1'b0, 1'b0, "R8 disabled falling");

        // R9: stamp register is read-only
        wr(2'd3, 64'hDEAD_BEEF_0000_1234);
        rd(2'd3, v);
        chk("R9 stamp write ignored", v, m_stamp);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule